// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation structure held in memory. A requester hands it one address at a time, with flags for a write access and for a user-mode access. The block reads the directory entry and, for a small page, the table entry. It then judges the access rights and, when needed, writes the leaf entry back with its accessed and dirty flags set. It ends by reporting a physical address with a write-permission flag, or a fault with a three-bit error code.

Control state is sampled when a request is accepted. This state covers paging enable, supervisor write protection, large-page enable, the directory base and a mask applied to every entry address (used to fold away address line 20). The memory side is a single-outstanding port: the block holds `mem_req` with a stable address until one `mem_ack` pulse returns. The walk runs through the states IDLE, DIR_RD, TBL_RD, CHECK, LEAF_WR and DONE, using these transitions:

- IDLE to DONE on an accepted request with paging off, or IDLE to DIR_RD with paging on.
- DIR_RD to DONE on a non-present directory entry.
- DIR_RD to CHECK on a large-page entry.
- DIR_RD to TBL_RD otherwise.
- TBL_RD to DONE on a non-present table entry, otherwise to CHECK.
- CHECK to DONE on a rights violation, or when no flag update is needed.
- CHECK to LEAF_WR when a flag update is needed.
- LEAF_WR to DONE on acknowledge.
- DONE always to IDLE.

Top module: `pgw_walker`

## Requirements
- R1: With paging off, a request completes with no memory access: `paddr` equals the virtual address, `writable` is 1 and `fault` is 0.
- R2: The directory entry is read from ((base with bits [11:0] cleared) + 4 × vaddr[31:22]) AND mask.
- R3: The table entry is read from ((directory entry with bits [11:0] cleared) + 4 × vaddr[21:12]) AND mask.
- R4: If bit 0 (present) of a fetched entry is 0, the walk ends with `fault`=1 and `err_code` = {user, write, 0}, with no further memory access. The error code bits are P=bit 0, W=bit 1, U=bit 2.
- R5: When directory bit 7 (size) is 1 and large pages are enabled, no table entry is read. `paddr` is {entry[31:22], vaddr[21:0]}, and rights come from the directory entry alone. With large pages disabled, bit 7 is ignored and the table is walked.
- R6: For a small page, the effective user bit (bit 2) and write bit (bit 1) are each the AND of the directory and table entries.
- R7: A user access faults if the effective user bit is 0, or if it is a write and the effective write bit is 0.
- R8: A supervisor access faults only when it is a write, write protection is on, the effective user bit is 1 and the effective write bit is 0.
- R9: If the leaf's accessed bit (bit 5) is 0, or the access is a write and the leaf's dirty bit (bit 6) is 0, the leaf is written back to its own address with bit 5 set, and bit 6 set for a write. Otherwise nothing is written.
- R10: `writable` is 1 only when the rights allow writing and the leaf was already dirty or the access is a write. The rights allow writing for a user access when the effective write bit is 1. For a supervisor access they allow it when protection is off, or the effective user bit is 0, or the effective write bit is 1.
- R11: A rights fault gives `fault`=1 and `err_code` = {user, write, 1}, with no write-back.
- R12: `req_ready` is high only in IDLE, and `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| paging_en | input | 1 | Translation enabled |
| wprot_en | input | 1 | Supervisor write protection |
| large_en | input | 1 | Large-page enable |
| dir_base | input | 32 | Directory base address |
| addr_mask | input | 32 | Mask ANDed into every entry address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Updated leaf entry |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 32 | Entry read data, valid with ack |
| done | output | 1 | Result valid (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| err_code | output | 3 | {U, W, P} error code |
| paddr | output | 32 | Physical address |
| writable | output | 1 | Write permitted for this translation |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high, for a single cycle per access, and that it never acknowledges in the same cycle the request first appears. The bench memory model issues a registered acknowledge one cycle after it sees a request and drops it the next cycle. This keeps the model within those assumptions. The control inputs are held steady while a request is offered, and each new request is sent only after the previous `done`.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DIR_RD,
        S_TBL_RD,
        S_CHECK,
        S_LEAF_WR,
        S_DONE
    } walk_state_t;

    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;
    localparam int BIT_PS = 7;

    localparam int ERR_P = 0;
    localparam int ERR_W = 1;
    localparam int ERR_U = 2;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
    parameter int AW     = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] index,
    input  logic [AW-1:0]    mask,
    output logic [AW-1:0]    addr
);
    localparam logic [AW-1:0] LOW_CLR = ~((AW'(1) << OFFS_W) - AW'(1));

    always_comb begin
        addr = ((base & LOW_CLR) + AW'({index, 2'b00})) & mask;
    end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm (
    input  logic eff_u,
    input  logic eff_rw,
    input  logic leaf_d,
    input  logic is_user,
    input  logic is_write,
    input  logic wprot,
    output logic deny,
    output logic wr_ok
);
    logic rights;

    always_comb begin
        if (is_user) begin
            deny   = !eff_u || (is_write && !eff_rw);
            rights = eff_rw;
        end else begin
            deny   = is_write && wprot && eff_u && !eff_rw;
            rights = !wprot || !eff_u || eff_rw;
        end
        wr_ok = rights && (leaf_d || is_write);
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
    parameter int AW     = 32,
    parameter int OFFS_W = 12,
    parameter int IDX_W  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          req_write,
    input  logic          req_user,
    input  logic          paging_en,
    input  logic          wprot_en,
    input  logic          large_en,
    input  logic [AW-1:0] dir_base,
    input  logic [AW-1:0] addr_mask,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          done,
    output logic          fault,
    output logic [2:0]    err_code,
    output logic [AW-1:0] paddr,
    output logic          writable
);
    import pgw_pkg::*;

    localparam int LOFFS_W = OFFS_W + IDX_W;

    walk_state_t state, nstate;

    logic [AW-1:0] va_q, base_q, mask_q, leaf_q, leaf_addr_q, paddr_q;
    logic          wr_q, usr_q, pg_q, wp_q, lp_q, large_q;
    logic          pde_u_q, pde_rw_q;
    logic          fault_q, wrok_q;
    logic [2:0]    err_q;

    logic [AW-1:0] dir_addr, tbl_addr;
    logic          eff_u, eff_rw, deny, wr_ok, need_upd;

    pgw_entry_addr #(.AW(AW), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_dir_addr (
        .base (base_q),
        .index(va_q[AW-1:LOFFS_W]),
        .mask (mask_q),
        .addr (dir_addr)
    );

    pgw_entry_addr #(.AW(AW), .OFFS_W(OFFS_W), .IDX_W(IDX_W)) u_tbl_addr (
        .base (leaf_q),
        .index(va_q[LOFFS_W-1:OFFS_W]),
        .mask (mask_q),
        .addr (tbl_addr)
    );

    always_comb begin
        eff_u  = large_q ? leaf_q[BIT_US] : (leaf_q[BIT_US] & pde_u_q);
        eff_rw = large_q ? leaf_q[BIT_RW] : (leaf_q[BIT_RW] & pde_rw_q);
        need_upd = !leaf_q[BIT_A] || (wr_q && !leaf_q[BIT_D]);
    end

    pgw_perm u_perm (
        .eff_u   (eff_u),
        .eff_rw  (eff_rw),
        .leaf_d  (leaf_q[BIT_D]),
        .is_user (usr_q),
        .is_write(wr_q),
        .wprot   (wp_q),
        .deny    (deny),
        .wr_ok   (wr_ok)
    );

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:    if (req_valid) nstate = paging_en ? S_DIR_RD : S_DONE;
            S_DIR_RD:  if (mem_ack) begin
                           if (!mem_rdata[BIT_P])                 nstate = S_DONE;
                           else if (mem_rdata[BIT_PS] && lp_q)   nstate = S_CHECK;
                           else                                   nstate = S_TBL_RD;
                       end
            S_TBL_RD:  if (mem_ack) nstate = mem_rdata[BIT_P] ? S_CHECK : S_DONE;
            S_CHECK:   nstate = (!deny && need_upd) ? S_LEAF_WR : S_DONE;
            S_LEAF_WR: if (mem_ack) nstate = S_DONE;
            S_DONE:    nstate = S_IDLE;
            default:   nstate = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // walk data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q <= '0; base_q <= '0; mask_q <= '0; leaf_q <= '0;
            leaf_addr_q <= '0; paddr_q <= '0;
            wr_q <= 1'b0; usr_q <= 1'b0; pg_q <= 1'b0; wp_q <= 1'b0;
            lp_q <= 1'b0; large_q <= 1'b0; pde_u_q <= 1'b0; pde_rw_q <= 1'b0;
            fault_q <= 1'b0; wrok_q <= 1'b0; err_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    wr_q    <= req_write;
                    usr_q   <= req_user;
                    pg_q    <= paging_en;
                    wp_q    <= wprot_en;
                    lp_q    <= large_en;
                    base_q  <= dir_base;
                    mask_q  <= addr_mask;
                    large_q <= 1'b0;
                    fault_q <= 1'b0;
                    err_q   <= '0;
                    paddr_q <= paging_en ? '0 : req_vaddr;
                    wrok_q  <= !paging_en;
                end
                S_DIR_RD: if (mem_ack) begin
                    leaf_q      <= mem_rdata;
                    leaf_addr_q <= dir_addr;
                    pde_u_q     <= mem_rdata[BIT_US];
                    pde_rw_q    <= mem_rdata[BIT_RW];
                    large_q     <= mem_rdata[BIT_PS] && lp_q;
                    if (!mem_rdata[BIT_P]) begin
                        fault_q <= 1'b1;
                        err_q   <= {usr_q, wr_q, 1'b0};
                    end
                end
                S_TBL_RD: if (mem_ack) begin
                    leaf_q      <= mem_rdata;
                    leaf_addr_q <= tbl_addr;
                    if (!mem_rdata[BIT_P]) begin
                        fault_q <= 1'b1;
                        err_q   <= {usr_q, wr_q, 1'b0};
                    end
                end
                S_CHECK: begin
                    if (deny) begin
                        fault_q <= 1'b1;
                        err_q   <= {usr_q, wr_q, 1'b1};
                    end else begin
                        paddr_q <= large_q ? {leaf_q[AW-1:LOFFS_W], va_q[LOFFS_W-1:0]}
                                           : {leaf_q[AW-1:OFFS_W], va_q[OFFS_W-1:0]};
                        wrok_q  <= wr_ok;
                    end
                end
                S_LEAF_WR, S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == S_IDLE);
        mem_req   = (state == S_DIR_RD) || (state == S_TBL_RD) || (state == S_LEAF_WR);
        mem_we    = (state == S_LEAF_WR);
        mem_addr  = '0;
        unique case (state)
            S_DIR_RD:  mem_addr = dir_addr;
            S_TBL_RD:  mem_addr = tbl_addr;
            S_LEAF_WR: mem_addr = leaf_addr_q;
            default:   mem_addr = '0;
        endcase
        mem_wdata        = leaf_q;
        mem_wdata[BIT_A] = 1'b1;
        if (wr_q) mem_wdata[BIT_D] = 1'b1;
        done     = (state == S_DONE);
        fault    = fault_q;
        err_code = err_q;
        paddr    = paddr_q;
        writable = wrok_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R12
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
    AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pg_q) |-> (paddr == va_q && writable && !fault)); // R1
    AST_LARGE_OFFS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && large_q) |-> (paddr[LOFFS_W-1:0] == va_q[LOFFS_W-1:0])); // R5
    AST_FAULT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> !writable); // R11
    AST_CLEAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (err_code == 3'b000)); // R4
    AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[BIT_A] && (mem_wdata[BIT_D] || !wr_q))); // R9
endmodule

// File: tb/pgw_walker_tb.sv
module pgw_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        paging_en = 1'b1, wprot_en = 1'b0, large_en = 1'b1;
    logic [31:0] dir_base = 32'h0000_1000, addr_mask = 32'hFFFF_FFFF;
    logic        req_ready, mem_req, mem_we, mem_ack, done, fault, writable;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, paddr;
    logic [2:0]  err_code;

    always #5 clk = ~clk;

    pgw_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .paging_en(paging_en), .wprot_en(wprot_en), .large_en(large_en),
        .dir_base(dir_base), .addr_mask(addr_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .err_code(err_code), .paddr(paddr), .writable(writable)
    );

    // memory model: 16 KB, registered one-cycle acknowledge
    logic [31:0] mem [0:4095];
    logic [31:0] log_addr [0:15];
    logic        log_we   [0:15];
    int          nacc_total = 0;
    logic        ack_r = 1'b0;
    logic [31:0] rdata_r = '0;
    assign mem_ack   = ack_r;
    assign mem_rdata = rdata_r;

    always @(posedge clk) begin
        ack_r <= 1'b0;
        if (mem_req && !ack_r) begin
            ack_r   <= 1'b1;
            rdata_r <= mem[mem_addr[13:2]];
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            log_addr[nacc_total % 16] <= mem_addr;
            log_we[nacc_total % 16]   <= mem_we;
            nacc_total <= nacc_total + 1;
        end
    end

    int npass = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        if (act === exp) npass++;
        else begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // results of the last walk
    logic        r_fault, r_wr, r_busy, r_after;
    logic [2:0]  r_err;
    logic [31:0] r_paddr;
    int          r_n, r_n0;

    task automatic walk(input logic [31:0] va, input logic w, input logic u);
        @(negedge clk);
        r_n0 = nacc_total;
        req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r_busy = !req_ready;
        for (int i = 0; i < 60 && !done; i++) @(negedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R12 actual=no-done expected=done");
        end
        r_fault = fault; r_err = err_code; r_paddr = paddr; r_wr = writable;
        r_n = nacc_total - r_n0;
        @(negedge clk);
        r_after = !done && req_ready;
    endtask

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem[a[13:2]];
    endfunction

    task automatic t_reset;
        chk("R12 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R12 done low after reset", {31'd0, done}, 32'd0);
        chk("R12 no mem req after reset", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_nopaging;
        paging_en = 1'b0;
        walk(32'hDEAD_BEEF, 1'b1, 1'b1);
        chk("R1 paddr", r_paddr, 32'hDEAD_BEEF);
        chk("R1 writable", {31'd0, r_wr}, 32'd1);
        chk("R1 fault", {31'd0, r_fault}, 32'd0);
        chk("R1 no access", r_n, 0);
        chk("R12 busy during walk", {31'd0, r_busy}, 32'd1);
        chk("R12 single done", {31'd0, r_after}, 32'd1);
        paging_en = 1'b1;
    endtask

    task automatic t_small_read;
        walk(32'h0040_5123, 1'b0, 1'b0);
        chk("R2 dir addr", log_addr[r_n0 % 16], 32'h0000_1004);
        chk("R3 tbl addr", log_addr[(r_n0 + 1) % 16], 32'h0000_2014);
        chk("R9 accessed writeback", mrd(32'h2014), 32'h0007_7027);
        chk("R9 three accesses", r_n, 3);
        chk("R9 write flagged", {31'd0, log_we[(r_n0 + 2) % 16]}, 32'd1);
        chk("R10 clean read not writable", {31'd0, r_wr}, 32'd0);
        chk("R3 paddr", r_paddr, 32'h0007_7123);
    endtask

    task automatic t_small_write;
        walk(32'h0040_5123, 1'b1, 1'b1);
        chk("R9 dirty writeback", mrd(32'h2014), 32'h0007_7067);
        chk("R10 write writable", {31'd0, r_wr}, 32'd1);
        chk("R7 user write ok", {31'd0, r_fault}, 32'd0);
    endtask

    task automatic t_and_rights;
        walk(32'h0080_3010, 1'b0, 1'b1);
        chk("R6 dir user clear faults", {31'd0, r_fault}, 32'd1);
        chk("R11 err user read", {29'd0, r_err}, 32'd5);
        chk("R11 no writeback", r_n, 2);
        chk("R11 entry kept", mrd(32'h200C), 32'h0005_5027);
        walk(32'h00C0_4000, 1'b1, 1'b1);
        chk("R7 user write ro", {31'd0, r_fault}, 32'd1);
        chk("R11 err user write", {29'd0, r_err}, 32'd7);
        walk(32'h00C0_4000, 1'b0, 1'b1);
        chk("R6 dir rw clear read ok", {31'd0, r_fault}, 32'd0);
        chk("R10 user ro not writable", {31'd0, r_wr}, 32'd0);
        chk("R9 dirty entry no write", r_n, 2);
    endtask

    task automatic t_supervisor;
        wprot_en = 1'b0;
        walk(32'h00C0_4000, 1'b1, 1'b0);
        chk("R8 sup write wp off", {31'd0, r_fault}, 32'd0);
        chk("R10 sup writable", {31'd0, r_wr}, 32'd1);
        chk("R8 paddr", r_paddr, 32'h0006_6000);
        wprot_en = 1'b1;
        walk(32'h00C0_4000, 1'b1, 1'b0);
        chk("R8 sup write wp on", {31'd0, r_fault}, 32'd1);
        chk("R11 err sup write", {29'd0, r_err}, 32'd3);
        walk(32'h00C0_4000, 1'b0, 1'b0);
        chk("R8 sup read wp on", {31'd0, r_fault}, 32'd0);
        chk("R10 sup ro wp on", {31'd0, r_wr}, 32'd0);
        wprot_en = 1'b0;
    endtask

    task automatic t_notpresent;
        walk(32'h0100_0000, 1'b1, 1'b1);
        chk("R4 dir absent", {31'd0, r_fault}, 32'd1);
        chk("R4 err", {29'd0, r_err}, 32'd6);
        chk("R4 one access", r_n, 1);
        walk(32'h0040_6000, 1'b0, 1'b0);
        chk("R4 tbl absent", {31'd0, r_fault}, 32'd1);
        chk("R4 err sup read", {29'd0, r_err}, 32'd0);
        chk("R4 two accesses", r_n, 2);
    endtask

    task automatic t_large;
        walk(32'h0141_2345, 1'b0, 1'b0);
        chk("R5 large paddr", r_paddr, 32'h0C01_2345);
        chk("R5 single read", r_n, 1);
        chk("R10 large clean ro", {31'd0, r_wr}, 32'd0);
        walk(32'h0141_2345, 1'b1, 1'b1);
        chk("R5 user write on dir rights", {31'd0, r_fault}, 32'd0);
        chk("R9 large dirty", mrd(32'h1014), 32'h0C0A_B0E7);
        chk("R9 large wb addr", log_addr[(r_n0 + 1) % 16], 32'h0000_1014);
        large_en = 1'b0;
        walk(32'h0141_2345, 1'b0, 1'b0);
        chk("R5 size bit ignored", log_addr[(r_n0 + 1) % 16], 32'h0C0A_B048);
        chk("R5 table absent fault", {31'd0, r_fault}, 32'd1);
        large_en = 1'b1;
    endtask

    task automatic t_mask;
        dir_base = 32'h0010_1000; addr_mask = 32'hFFEF_FFFF;
        walk(32'h0040_5123, 1'b0, 1'b0);
        chk("R2 masked dir addr", log_addr[r_n0 % 16], 32'h0000_1004);
        chk("R10 dirty read writable", {31'd0, r_wr}, 32'd1);
        chk("R9 no wb when dirty", r_n, 2);
        dir_base = 32'h0000_1000; addr_mask = 32'hFFFF_FFFF;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        mem[32'h1004 >> 2] = 32'h0000_2007;
        mem[32'h1008 >> 2] = 32'h0000_2003;
        mem[32'h100C >> 2] = 32'h0000_2005;
        mem[32'h1014 >> 2] = 32'h0C0A_B0A7;
        mem[32'h2014 >> 2] = 32'h0007_7007;
        mem[32'h200C >> 2] = 32'h0005_5027;
        mem[32'h2010 >> 2] = 32'h0006_6067;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_nopaging;
        t_small_read;
        t_small_write;
        t_and_rights;
        t_supervisor;
        t_notpresent;
        t_large;
        t_mask;
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", npass, npass + nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nfail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  %0d/%0d checks passed", npass, npass + nfail);
            $finish;
        end
    end
endmodule